// File: doc/BRIEF.md
# Bus Error Snapshot Register

This block keeps a 32-bit picture of the bus interface for error analysis. It watches live state from two places: the DMA path (its command, its dual-address flag and the one-hot window-hit vector) and the bus interface (its current command, its dual-address flag, and the codes of its target and master state machines). While no error is pending, the read word shows this live state directly. When an error bit from either error class is raised, the block captures the state shown in that cycle. It then holds the picture until software clears the main error status register.

Error bits belong to one of two classes. The memory/DMA class is bits 0, 1, 3 and 9: correctable ECC, uncorrectable ECC, nonexistent memory and bad page-table entry. The bus class is bits 5, 6, 7, 8 and 11: data parity, address parity, master abort, target abort and I/O timeout. Other bits of the vector are not snapshot errors. Illegal window or master-state codes are cleaned before they are shown or captured.

The lock sequencer has two states, OPEN and HELD:
- OPEN goes to HELD on any class error (transition "seize"), and the word is captured on that edge.
- OPEN stays OPEN otherwise (transition "track").
- HELD stays HELD while no clear arrives (transition "keep").
- HELD goes back to OPEN on a clear with no class error (transition "release").
- HELD stays HELD on a clear together with a class error (transition "reseize"), and the word is captured again.

Top module: `bus_err_snapshot`

## Requirements
- R1: The synchronous active-high reset leaves the block unlocked (`snap_locked`=0). After reset, `snap_word` shows the packed live state.
- R2: While unlocked, a class error bit raises `snap_locked` on the next edge. From then on the word equals the live state presented in the cycle of that error.
- R3: While locked and with no clear, the word and the lock do not change, whatever the live inputs or further error bits.
- R4: A clear with no class error in the same cycle releases the lock on the next edge. The word then follows live state again.
- R5: A clear and a class error in the same cycle keep the block locked and recapture the state of that cycle.
- R6: Error bits 2, 4 and 10 belong to neither class. Alone, they neither lock nor capture.
- R7: Word layout: bit 28 is the bus dual-address flag, 27:24 the bus command, 23:20 the target state, 19:16 the master state, 11:8 the window vector, bit 5 the DMA dual-address flag, and 3:0 the DMA command.
- R8: Bits 31:29, 15:12, 7:6 and 4 always read zero.
- R9: A window input with more than one bit set is shown and captured as 0000. Values 0000, 0001, 0010, 0100 and 1000 pass unchanged.
- R10: A master state code from B to F is shown and captured as F (unknown). Codes 0 to A pass unchanged. Target state codes pass unchanged.
- R11: A clear while unlocked has no effect: the block stays unlocked and the word keeps following live state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_cmd | input | 4 | Live DMA command |
| dma_dac | input | 1 | Live DMA dual-address flag |
| dma_win | input | 4 | Live one-hot window hit |
| bus_cmd | input | 4 | Live bus command |
| bus_dac | input | 1 | Live bus dual-address flag |
| bus_tgt | input | 4 | Live target state code |
| bus_mst | input | 4 | Live master state code |
| err_vec | input | ERR_W (12) | Error bits |
| err_clr | input | 1 | Clear strobe of the main error status register |
| snap_word | output | 32 | Packed status word |
| snap_locked | output | 1 | Lock indicator |

## Verification
The bench builds the block with its default parameters: a 12-bit error vector and the two default class masks. This puts every error bit within reach, including the unclassified bits 2, 4 and 10, which must neither lock nor capture. Random window and master codes span all 16 values, so the illegal encodings reach the cleaning logic both while the word is live and at capture. Random clears fall at random points, some while unlocked and some in the same cycle as an error.

// File: rtl/bes_pkg.sv
package bes_pkg;
    localparam int CMD_W = 4;
    localparam int ST_W  = 4;
    localparam int WIN_W = 4;
    localparam int WORD_W = 32;

    localparam logic [ST_W-1:0] MST_LAST_LEGAL = 4'hA;
    localparam logic [ST_W-1:0] MST_UNKNOWN    = 4'hF;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic             dac;
        logic [WIN_W-1:0] win;
    } dma_view_t;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic             dac;
        logic [ST_W-1:0]  tgt;
        logic [ST_W-1:0]  mst;
    } bus_view_t;
endpackage

// File: rtl/snap_lock_fsm.sv
module snap_lock_fsm
    import bes_pkg::*;
#(
    parameter int               ERR_W    = 12,
    parameter logic [ERR_W-1:0] DMA_MASK = 12'h20B,
    parameter logic [ERR_W-1:0] BUS_MASK = 12'h9E0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ERR_W-1:0] err_vec,
    input  logic             err_clr,
    output logic             locked,
    output logic             capture
);
    localparam logic [ERR_W-1:0] CLASS_MASK = DMA_MASK | BUS_MASK;

    lock_state_e state_q, state_d;
    logic        trig;
    logic        stray;

    assign trig  = |(err_vec & CLASS_MASK);
    assign stray = |(err_vec & ~CLASS_MASK);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (trig) state_d = LK_HELD;
            LK_HELD: if (err_clr && !trig) state_d = LK_OPEN;
            default: state_d = LK_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LK_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        locked  = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            LK_OPEN: begin
                locked  = 1'b0;
                capture = trig;
            end
            LK_HELD: begin
                locked  = 1'b1;
                capture = trig && err_clr;
            end
            default: begin
                locked  = 1'b0;
                capture = 1'b0;
            end
        endcase
    end

    p_seize_r2: assert property (@(posedge clk) disable iff (rst)
        (!locked && trig) |=> locked);
    p_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (locked && !err_clr) |=> locked);
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && err_clr && !trig) |=> !locked);
    p_reseize_r5: assert property (@(posedge clk) disable iff (rst)
        (locked && err_clr && trig) |=> locked);
    p_stray_r6: assert property (@(posedge clk) disable iff (rst)
        (!locked && stray && !trig) |=> !locked);
    p_idle_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (!locked && !trig && err_clr) |=> !locked);
endmodule

// File: rtl/snap_field_clean.sv
module snap_field_clean
    import bes_pkg::*;
(
    input  dma_view_t dma_raw,
    input  bus_view_t bus_raw,
    output dma_view_t dma_ok,
    output bus_view_t bus_ok
);
    logic [WIN_W:0] hot_cnt;

    always_comb begin
        hot_cnt = '0;
        for (int i = 0; i < WIN_W; i++) begin
            hot_cnt = hot_cnt + {{WIN_W{1'b0}}, dma_raw.win[i]};
        end
    end

    always_comb begin
        dma_ok = dma_raw;
        if (hot_cnt > 1) dma_ok.win = '0;
        bus_ok = bus_raw;
        if (bus_raw.mst > MST_LAST_LEGAL) bus_ok.mst = MST_UNKNOWN;
    end
endmodule

// File: rtl/snap_word_pack.sv
module snap_word_pack
    import bes_pkg::*;
(
    input  dma_view_t          dma_v,
    input  bus_view_t          bus_v,
    output logic [WORD_W-1:0]  word
);
    always_comb begin
        word        = '0;
        word[28]    = bus_v.dac;
        word[27:24] = bus_v.cmd;
        word[23:20] = bus_v.tgt;
        word[19:16] = bus_v.mst;
        word[11:8]  = dma_v.win;
        word[5]     = dma_v.dac;
        word[3:0]   = dma_v.cmd;
    end
endmodule

// File: rtl/bus_err_snapshot.sv
module bus_err_snapshot
    import bes_pkg::*;
#(
    parameter int               ERR_W    = 12,
    parameter logic [ERR_W-1:0] DMA_MASK = 12'h20B,
    parameter logic [ERR_W-1:0] BUS_MASK = 12'h9E0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        dma_cmd,
    input  logic              dma_dac,
    input  logic [3:0]        dma_win,
    input  logic [3:0]        bus_cmd,
    input  logic              bus_dac,
    input  logic [3:0]        bus_tgt,
    input  logic [3:0]        bus_mst,
    input  logic [ERR_W-1:0]  err_vec,
    input  logic              err_clr,
    output logic [31:0]       snap_word,
    output logic              snap_locked
);
    dma_view_t dma_raw, dma_live, dma_q, dma_sel;
    bus_view_t bus_raw, bus_live, bus_q, bus_sel;
    logic      locked, capture;

    assign dma_raw = '{cmd: dma_cmd, dac: dma_dac, win: dma_win};
    assign bus_raw = '{cmd: bus_cmd, dac: bus_dac, tgt: bus_tgt, mst: bus_mst};

    snap_lock_fsm #(.ERR_W(ERR_W), .DMA_MASK(DMA_MASK), .BUS_MASK(BUS_MASK)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .err_vec (err_vec),
        .err_clr (err_clr),
        .locked  (locked),
        .capture (capture)
    );

    snap_field_clean u_clean (
        .dma_raw (dma_raw),
        .bus_raw (bus_raw),
        .dma_ok  (dma_live),
        .bus_ok  (bus_live)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_q <= '0;
            bus_q <= '0;
        end else if (capture) begin
            dma_q <= dma_live;
            bus_q <= bus_live;
        end
    end

    assign dma_sel = locked ? dma_q : dma_live;
    assign bus_sel = locked ? bus_q : bus_live;

    snap_word_pack u_pack (
        .dma_v (dma_sel),
        .bus_v (bus_sel),
        .word  (snap_word)
    );

    assign snap_locked = locked;

    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (snap_locked && !err_clr) |=> $stable(snap_word));
    p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (snap_word[31:29] == 3'b0) && (snap_word[15:12] == 4'b0)
        && (snap_word[7:6] == 2'b0) && !snap_word[4]);
    p_window_legal_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(snap_word[11:8]));
    p_master_legal_r10: assert property (@(posedge clk) disable iff (rst)
        (snap_word[19:16] <= 4'hA) || (snap_word[19:16] == 4'hF));
endmodule

// File: tb/tb_bus_err_snapshot.sv
module tb_bus_err_snapshot;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  dma_cmd, dma_win, bus_cmd, bus_tgt, bus_mst;
    logic        dma_dac, bus_dac, err_clr;
    logic [11:0] err_vec;
    logic [31:0] snap_word;
    logic        snap_locked;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic        m_locked;
    logic [31:0] m_snap;

    localparam logic [11:0] CLASS_BITS = 12'h20B | 12'h9E0;

    always #5 clk = ~clk;

    bus_err_snapshot dut (
        .clk(clk), .rst(rst),
        .dma_cmd(dma_cmd), .dma_dac(dma_dac), .dma_win(dma_win),
        .bus_cmd(bus_cmd), .bus_dac(bus_dac), .bus_tgt(bus_tgt), .bus_mst(bus_mst),
        .err_vec(err_vec), .err_clr(err_clr),
        .snap_word(snap_word), .snap_locked(snap_locked)
    );

    function automatic logic [31:0] live_word();
        logic [3:0] w, m;
        w = ($countones(dma_win) > 1) ? 4'h0 : dma_win;
        m = (bus_mst > 4'hA) ? 4'hF : bus_mst;
        return {3'b0, bus_dac, bus_cmd, bus_tgt, m, 4'b0, w, 2'b0, dma_dac, 1'b0, dma_cmd};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic trig;
        #1;
        chk(tag, {31'b0, snap_locked}, {31'b0, m_locked});
        chk(tag, snap_word, m_locked ? m_snap : live_word());
        @(posedge clk);
        trig = |(err_vec & CLASS_BITS);
        if (!m_locked) begin
            if (trig) begin m_locked = 1'b1; m_snap = live_word(); end
        end else if (err_clr) begin
            if (trig) m_snap = live_word();
            else m_locked = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic set_live(input logic [3:0] dc, input logic dd, input logic [3:0] dw,
                            input logic [3:0] bc, input logic bd, input logic [3:0] bt,
                            input logic [3:0] bm);
        dma_cmd = dc; dma_dac = dd; dma_win = dw;
        bus_cmd = bc; bus_dac = bd; bus_tgt = bt; bus_mst = bm;
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; err_vec = '0; err_clr = 1'b0;
        set_live(4'h0, 1'b0, 4'h0, 4'h0, 1'b0, 4'h0, 4'h0);
        m_locked = 1'b0; m_snap = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: unlocked after reset, live word shown
        set_live(4'h3, 1'b1, 4'h1, 4'h6, 1'b0, 4'h2, 4'h4);
        step("R1");
        // R7: exact layout
        set_live(4'h7, 1'b1, 4'h4, 4'hC, 1'b1, 4'h9, 4'hA);
        #1 chk("R7", snap_word, 32'h1C9A_0427);
        step("R7");
        // R8 and R9: multi-hot window cleaned, reserved bits zero
        set_live(4'hF, 1'b1, 4'h6, 4'hF, 1'b1, 4'hF, 4'h2);
        #1 chk("R9", {20'b0, snap_word[11:8], 8'b0}, 32'h0);
        chk("R8", snap_word & 32'hE000_F0D0, 32'h0);
        step("R9");
        // R10: master code C shown as F
        set_live(4'h1, 1'b0, 4'h8, 4'h2, 1'b0, 4'h3, 4'hC);
        #1 chk("R10", {28'b0, snap_word[19:16]}, 32'hF);
        step("R10");
        // R11: clear while unlocked
        err_clr = 1'b1; step("R11");
        err_clr = 1'b0; step("R11");
        // R6: unclassified bits alone
        err_vec = 12'h414; step("R6");
        err_vec = '0; step("R6");
        // R2: correctable ECC error captures
        set_live(4'hA, 1'b1, 4'h2, 4'h5, 1'b1, 4'h7, 4'hE);
        err_vec = 12'h001; step("R2");
        err_vec = '0;
        set_live(4'h2, 1'b0, 4'h1, 4'h1, 1'b0, 4'h1, 4'h1);
        step("R2");
        // R3: further errors ignored while held
        err_vec = 12'h020; step("R3");
        set_live(4'h9, 1'b1, 4'h8, 4'h3, 1'b1, 4'h4, 4'h5);
        err_vec = 12'h800; step("R3");
        err_vec = '0; step("R3");
        // R5: clear plus I/O timeout recaptures
        set_live(4'h4, 1'b0, 4'h8, 4'hB, 1'b1, 4'h8, 4'hF);
        err_clr = 1'b1; err_vec = 12'h800; step("R5");
        err_clr = 1'b0; err_vec = '0;
        set_live(4'h0, 1'b0, 4'h0, 4'h0, 1'b0, 4'h0, 4'h0);
        step("R5");
        // R4: clear alone releases
        err_clr = 1'b1; step("R4");
        err_clr = 1'b0;
        set_live(4'h6, 1'b1, 4'h4, 4'h7, 1'b0, 4'h6, 4'h9);
        step("R4");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            set_live(4'($urandom), 1'($urandom), 4'($urandom), 4'($urandom),
                     1'($urandom), 4'($urandom), 4'($urandom));
            err_vec = ($urandom % 6 == 0) ? (12'h1 << ($urandom % 12)) : 12'h0;
            err_clr = ($urandom % 8 == 0);
            if (m_locked && err_clr && |(err_vec & CLASS_BITS)) step("R5");
            else if (m_locked && err_clr) step("R4");
            else if (m_locked) step("R3");
            else step("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule